// File: doc/BRIEF.md
# Sub-Dword Operand Select and Merge

This block sits around a 32-bit ALU so that the ALU can work on byte and halfword fields without extra shift or mask instructions. On the way in, it picks one field out of each of two source operands and widens that field to a full word. The widening is either signed or unsigned, chosen by a per-source flag. On the way out, it places the ALU result into a chosen field of the destination word. A policy input decides what happens to the destination bits outside that field: they are cleared, they are filled from the sign of the field, or they keep the old destination value.

One transaction is presented each cycle that the valid strobe is high. The widened operands, the merged destination and an output valid all appear one clock later from registers. The ALU between the two halves is not part of this block. Its result and the old destination value arrive as plain inputs.

Top module: `subdw_select_merge`

## Requirements
- R1: Select code 1 takes bits 7:0, 2 takes 15:8, 3 takes 23:16, 4 takes 31:24, 5 takes 15:0 and 6 takes 31:16. With the sign-extend flag low, a source's field appears right-aligned in its widened output, and all higher bits are zero.
- R2: With the sign-extend flag high and a sub-word select, every bit of the widened output above the field equals the field's most significant bit.
- R3: Select code 0 passes the whole 32-bit source through unchanged, and the sign-extend flag has no effect.
- R4: Select code 7 behaves exactly like code 0, for both the sources and the destination.
- R5: The destination field chosen by the destination select receives the low bits of the ALU result, shifted up to the field's position.
- R6: Policy 0 writes zero to every destination bit outside the selected field.
- R7: Policy 1 copies the field's most significant bit into every destination bit above the field and writes zero below it.
- R8: Policy 2 keeps the old destination value in every bit outside the field. Policy 3 behaves the same way.
- R9: The output valid equals the input valid of the previous cycle, and each result appears exactly one cycle after its input. While the input valid is low, all data outputs hold their values.
- R10: While reset is asserted, the output valid and all data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Transaction strobe |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand |
| sel_a | input | 3 | Field select for src_a |
| sel_b | input | 3 | Field select for src_b |
| sext_a | input | 1 | Signed widening of the src_a field |
| sext_b | input | 1 | Signed widening of the src_b field |
| alu_res | input | 32 | ALU result to insert |
| dst_old | input | 32 | Previous destination value |
| dst_sel | input | 3 | Destination field select |
| unused_pol | input | 2 | Policy for unselected destination bits |
| out_valid | output | 1 | Registered valid, one cycle after in_valid |
| opnd_a | output | 32 | Widened src_a field |
| opnd_b | output | 32 | Widened src_b field |
| dst_out | output | 32 | Merged destination word |

## Verification
Source widening and destination merging take effect in the same transaction. Each uses its own select and its own sign rule, so the bench crosses them. One example is a negative source byte widened with the sign-extend flag while the destination uses the sign-fill policy on a different field.

A sweep covers every destination select with every policy, including codes 7 and 3. Each source select in the sweep gets a different sign-extend setting, and the transactions run back to back. Every item's expected operands and merged word are computed from the requirements and queued. The monitor then compares each item one cycle later, and it checks that the outputs are held across idle gaps.

// File: rtl/subdw_pkg.sv
`timescale 1ns/1ps
package subdw_pkg;
  typedef enum logic [2:0] {
    SEL_FULL = 3'd0,
    SEL_B0   = 3'd1,
    SEL_B1   = 3'd2,
    SEL_B2   = 3'd3,
    SEL_B3   = 3'd4,
    SEL_H0   = 3'd5,
    SEL_H1   = 3'd6,
    SEL_ALT  = 3'd7
  } sel_e;

  typedef enum logic [1:0] {
    POL_ZERO = 2'd0,
    POL_SIGN = 2'd1,
    POL_KEEP = 2'd2,
    POL_ALT  = 2'd3
  } pol_e;
endpackage

// File: rtl/subdw_field_decode.sv
`timescale 1ns/1ps
module subdw_field_decode #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int WID_W = IDX_W + 1
) (
  input  logic [2:0]       sel,
  output logic [IDX_W-1:0] lsb,
  output logic [WID_W-1:0] wid
);
  import subdw_pkg::*;
  localparam int BYTE_W = DATA_W / 4;
  localparam int HALF_W = DATA_W / 2;

  always_comb begin
    lsb = '0;
    wid = WID_W'(DATA_W);
    case (sel_e'(sel))
      SEL_B0: begin lsb = '0;                    wid = WID_W'(BYTE_W); end
      SEL_B1: begin lsb = IDX_W'(BYTE_W);        wid = WID_W'(BYTE_W); end
      SEL_B2: begin lsb = IDX_W'(2 * BYTE_W);    wid = WID_W'(BYTE_W); end
      SEL_B3: begin lsb = IDX_W'(3 * BYTE_W);    wid = WID_W'(BYTE_W); end
      SEL_H0: begin lsb = '0;                    wid = WID_W'(HALF_W); end
      SEL_H1: begin lsb = IDX_W'(HALF_W);        wid = WID_W'(HALF_W); end
      default: begin lsb = '0;                   wid = WID_W'(DATA_W); end
    endcase
  end
endmodule

// File: rtl/subdw_src_extract.sv
`timescale 1ns/1ps
module subdw_src_extract #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opnd,
  input  logic [2:0]        sel,
  input  logic              sext,
  output logic [DATA_W-1:0] wide
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam int WID_W = IDX_W + 1;

  logic [IDX_W-1:0]  lsb;
  logic [WID_W-1:0]  wid;
  logic [DATA_W-1:0] shifted;
  logic [IDX_W-1:0]  top_idx;
  logic              fill;

  subdw_field_decode #(.DATA_W(DATA_W)) u_dec (
    .sel (sel),
    .lsb (lsb),
    .wid (wid)
  );

  assign shifted = opnd >> lsb;
  assign top_idx = IDX_W'(wid - WID_W'(1));
  assign fill    = sext & shifted[top_idx];

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(wid)) wide[i] = shifted[i];
      else               wide[i] = fill;
    end
  end
endmodule

// File: rtl/subdw_dst_merge.sv
`timescale 1ns/1ps
module subdw_dst_merge #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] res,
  input  logic [DATA_W-1:0] old,
  input  logic [2:0]        sel,
  input  logic [1:0]        pol,
  output logic [DATA_W-1:0] merged
);
  import subdw_pkg::*;
  localparam int IDX_W = $clog2(DATA_W);
  localparam int WID_W = IDX_W + 1;

  logic [IDX_W-1:0] lsb;
  logic [WID_W-1:0] wid;
  logic [WID_W-1:0] hi_lim;
  logic [IDX_W-1:0] top_idx;
  logic             sign_bit;
  logic             clr_below;
  logic             clr_above;

  subdw_field_decode #(.DATA_W(DATA_W)) u_dec (
    .sel (sel),
    .lsb (lsb),
    .wid (wid)
  );

  assign hi_lim    = WID_W'(lsb) + wid;
  assign top_idx   = IDX_W'(wid - WID_W'(1));
  assign sign_bit  = res[top_idx];
  assign clr_below = (pol_e'(pol) == POL_ZERO) || (pol_e'(pol) == POL_SIGN);
  assign clr_above = (pol_e'(pol) == POL_ZERO);

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(lsb)) begin
        merged[i] = clr_below ? 1'b0 : old[i];
      end else if (i < int'(hi_lim)) begin
        merged[i] = res[IDX_W'(i - int'(lsb))];
      end else if (pol_e'(pol) == POL_SIGN) begin
        merged[i] = sign_bit;
      end else begin
        merged[i] = clr_above ? 1'b0 : old[i];
      end
    end
  end
endmodule

// File: rtl/subdw_select_merge.sv
`timescale 1ns/1ps
module subdw_select_merge #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [2:0]        sel_a,
  input  logic [2:0]        sel_b,
  input  logic              sext_a,
  input  logic              sext_b,
  input  logic [DATA_W-1:0] alu_res,
  input  logic [DATA_W-1:0] dst_old,
  input  logic [2:0]        dst_sel,
  input  logic [1:0]        unused_pol,
  output logic              out_valid,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] dst_out
);
  localparam int NUM_SRC = 2;

  logic [DATA_W-1:0] src_v  [NUM_SRC];
  logic [2:0]        sel_v  [NUM_SRC];
  logic              sext_v [NUM_SRC];
  logic [DATA_W-1:0] wide_v [NUM_SRC];
  logic [DATA_W-1:0] opnd_q [NUM_SRC];
  logic [DATA_W-1:0] opnd_d [NUM_SRC];

  assign src_v[0]  = src_a;
  assign src_v[1]  = src_b;
  assign sel_v[0]  = sel_a;
  assign sel_v[1]  = sel_b;
  assign sext_v[0] = sext_a;
  assign sext_v[1] = sext_b;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    subdw_src_extract #(.DATA_W(DATA_W)) u_ext (
      .opnd (src_v[g]),
      .sel  (sel_v[g]),
      .sext (sext_v[g]),
      .wide (wide_v[g])
    );
  end

  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] dst_q;
  logic [DATA_W-1:0] dst_d;
  logic              vld_q;

  subdw_dst_merge #(.DATA_W(DATA_W)) u_merge (
    .res    (alu_res),
    .old    (dst_old),
    .sel    (dst_sel),
    .pol    (unused_pol),
    .merged (merged)
  );

  // next-state: load on valid, otherwise hold
  always_comb begin
    for (int s = 0; s < NUM_SRC; s++) begin
      opnd_d[s] = in_valid ? wide_v[s] : opnd_q[s];
    end
    dst_d = in_valid ? merged : dst_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dst_q <= '0;
      for (int s = 0; s < NUM_SRC; s++) opnd_q[s] <= '0;
    end else begin
      vld_q <= in_valid;
      dst_q <= dst_d;
      for (int s = 0; s < NUM_SRC; s++) opnd_q[s] <= opnd_d[s];
    end
  end

  assign out_valid = vld_q;
  assign opnd_a    = opnd_q[0];
  assign opnd_b    = opnd_q[1];
  assign dst_out   = dst_q;
endmodule

// File: rtl/subdw_select_merge_chk.sv
`timescale 1ns/1ps
module subdw_select_merge_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] src_a,
  input logic [2:0]        sel_a,
  input logic              sext_a,
  input logic [DATA_W-1:0] alu_res,
  input logic [DATA_W-1:0] dst_old,
  input logic [2:0]        dst_sel,
  input logic [1:0]        unused_pol,
  input logic              out_valid,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] dst_out
);
  localparam int BYTE_W = DATA_W / 4;

  // R9: valid is delayed by exactly one cycle
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r9_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(dst_out) && $stable(opnd_a)));

  // R1: unsigned low byte has zero upper bits
  a_r1_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sel_a == 3'd1 && !sext_a) |=>
      (opnd_a[DATA_W-1:BYTE_W] == '0 && opnd_a[BYTE_W-1:0] == $past(src_a[BYTE_W-1:0])));

  // R2: signed low byte fills from bit BYTE_W-1
  a_r2_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sel_a == 3'd1 && sext_a) |=>
      (opnd_a[DATA_W-1:BYTE_W] == {(DATA_W-BYTE_W){$past(src_a[BYTE_W-1])}}));

  // R3: whole-word select passes the source
  a_r3_full_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sel_a == 3'd0) |=> (opnd_a == $past(src_a)));

  // R6: zero policy on low byte clears the rest
  a_r6_pad_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dst_sel == 3'd1 && unused_pol == 2'd0) |=>
      (dst_out == {{(DATA_W-BYTE_W){1'b0}}, $past(alu_res[BYTE_W-1:0])}));

  // R8: keep policy on low byte retains old upper bits
  a_r8_keep_old: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dst_sel == 3'd1 && unused_pol == 2'd2) |=>
      (dst_out[DATA_W-1:BYTE_W] == $past(dst_old[DATA_W-1:BYTE_W])));

  // R10: reset clears the strobe
  always @(posedge clk) begin
    if (!rst_n) a_r10_reset_idle: assert (!out_valid);
  end
endmodule

bind subdw_select_merge subdw_select_merge_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .src_a      (src_a),
  .sel_a      (sel_a),
  .sext_a     (sext_a),
  .alu_res    (alu_res),
  .dst_old    (dst_old),
  .dst_sel    (dst_sel),
  .unused_pol (unused_pol),
  .out_valid  (out_valid),
  .opnd_a     (opnd_a),
  .dst_out    (dst_out)
);

// File: tb/subdw_select_merge_bench.sv
`timescale 1ns/1ps
module subdw_select_merge_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] src_a, src_b, alu_res, dst_old;
  logic [2:0]  sel_a, sel_b, dst_sel;
  logic        sext_a, sext_b;
  logic [1:0]  unused_pol;
  logic        out_valid;
  logic [31:0] opnd_a, opnd_b, dst_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  subdw_select_merge u_subdw_select_merge (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .src_a(src_a), .src_b(src_b), .sel_a(sel_a), .sel_b(sel_b),
    .sext_a(sext_a), .sext_b(sext_b), .alu_res(alu_res), .dst_old(dst_old),
    .dst_sel(dst_sel), .unused_pol(unused_pol),
    .out_valid(out_valid), .opnd_a(opnd_a), .opnd_b(opnd_b), .dst_out(dst_out)
  );

  typedef struct {
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] d;
    string       tag;
  } exp_t;

  exp_t sb[$];
  exp_t last;
  bit   have_last = 1'b0;

  function automatic logic [31:0] m_widen(logic [31:0] v, logic [2:0] s, logic x);
    case (s)
      3'd1: return x ? {{24{v[7]}},  v[7:0]}   : {24'h0, v[7:0]};
      3'd2: return x ? {{24{v[15]}}, v[15:8]}  : {24'h0, v[15:8]};
      3'd3: return x ? {{24{v[23]}}, v[23:16]} : {24'h0, v[23:16]};
      3'd4: return x ? {{24{v[31]}}, v[31:24]} : {24'h0, v[31:24]};
      3'd5: return x ? {{16{v[15]}}, v[15:0]}  : {16'h0, v[15:0]};
      3'd6: return x ? {{16{v[31]}}, v[31:16]} : {16'h0, v[31:16]};
      default: return v;
    endcase
  endfunction

  function automatic logic [31:0] m_merge(logic [31:0] r, logic [31:0] o,
                                          logic [2:0] s, logic [1:0] p);
    int lo, w;
    logic [31:0] e;
    case (s)
      3'd1: begin lo = 0;  w = 8;  end
      3'd2: begin lo = 8;  w = 8;  end
      3'd3: begin lo = 16; w = 8;  end
      3'd4: begin lo = 24; w = 8;  end
      3'd5: begin lo = 0;  w = 16; end
      3'd6: begin lo = 16; w = 16; end
      default: begin lo = 0; w = 32; end
    endcase
    for (int k = 0; k < 32; k++) begin
      if (k >= lo && k < lo + w) e[k] = r[k - lo];
      else if (p == 2'd0)        e[k] = 1'b0;
      else if (p == 2'd1)        e[k] = (k < lo) ? 1'b0 : r[w - 1];
      else                       e[k] = o[k];
    end
    return e;
  endfunction

  task automatic cmp(string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  task automatic send(string tag, logic [31:0] a, logic [2:0] sa, logic xa,
                      logic [31:0] b, logic [2:0] sb_, logic xb,
                      logic [31:0] r, logic [31:0] o, logic [2:0] ds, logic [1:0] p);
    exp_t it;
    @(negedge clk);
    in_valid = 1'b1;
    src_a = a; sel_a = sa; sext_a = xa;
    src_b = b; sel_b = sb_; sext_b = xb;
    alu_res = r; dst_old = o; dst_sel = ds; unused_pol = p;
    it.a = m_widen(a, sa, xa);
    it.b = m_widen(b, sb_, xb);
    it.d = m_merge(r, o, ds, p);
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      src_a = ~src_a; alu_res = ~alu_res; dst_old = ~dst_old;
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1) begin
        if (out_valid === 1'b1) begin
          if (sb.size() == 0) begin
            checks++; errors++;
            $display("FAIL R9 out_valid got 1 exp 0");
          end else begin
            exp_t it;
            it = sb.pop_front();
            cmp(it.tag, "opnd_a", opnd_a, it.a);
            cmp(it.tag, "opnd_b", opnd_b, it.b);
            cmp(it.tag, "dst_out", dst_out, it.d);
            last = it;
            have_last = 1'b1;
          end
        end else if (have_last) begin
          cmp("R9 hold", "dst_out", dst_out, last.d);
          cmp("R9 hold", "opnd_a", opnd_a, last.a);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    rst_n = 1'b0; in_valid = 1'b0;
    src_a = 32'hA5A5A5A5; src_b = 32'h5A5A5A5A; sel_a = 0; sel_b = 0;
    sext_a = 0; sext_b = 0; alu_res = 32'hFFFFFFFF; dst_old = 32'hFFFFFFFF;
    dst_sel = 0; unused_pol = 2;
    repeat (3) @(negedge clk);
    cmp("R10", "out_valid", {31'h0, out_valid}, 32'h0);
    cmp("R10", "opnd_a", opnd_a, 32'h0);
    cmp("R10", "opnd_b", opnd_b, 32'h0);
    cmp("R10", "dst_out", dst_out, 32'h0);
    rst_n = 1'b1;

    // R1 unsigned fields
    send("R1", 32'h89ABCDEF, 3'd2, 1'b0, 32'h89ABCDEF, 3'd6, 1'b0,
         32'h0, 32'h0, 3'd0, 2'd0);
    // R2 signed fields, negative and positive
    send("R2", 32'h89ABCDEF, 3'd2, 1'b1, 32'h12347FFF, 3'd5, 1'b1,
         32'h0, 32'h0, 3'd0, 2'd0);
    // R3 whole word ignores the sign flag
    send("R3", 32'h80000001, 3'd0, 1'b1, 32'hFFFF0000, 3'd0, 1'b1,
         32'h0, 32'h0, 3'd0, 2'd0);
    // R4 code 7 as whole word, source and destination
    send("R4", 32'h80000001, 3'd7, 1'b1, 32'h00008000, 3'd7, 1'b1,
         32'hCAFEF00D, 32'h11111111, 3'd7, 2'd0);
    // R5 R6 insert byte 2, zero the rest
    send("R5 R6", 32'h0, 3'd0, 1'b0, 32'h0, 3'd0, 1'b0,
         32'h123456A5, 32'hFFFFFFFF, 3'd3, 2'd0);
    // R7 sign fill, negative then positive field
    send("R7", 32'h0, 3'd0, 1'b0, 32'h0, 3'd0, 1'b0,
         32'h000000A5, 32'hFFFFFFFF, 3'd3, 2'd1);
    send("R7", 32'h0, 3'd0, 1'b0, 32'h0, 3'd0, 1'b0,
         32'hFFFFFF25, 32'hFFFFFFFF, 3'd3, 2'd1);
    // R8 keep old, policy 2 and 3
    send("R8", 32'h0, 3'd0, 1'b0, 32'h0, 3'd0, 1'b0,
         32'h00000077, 32'h11223344, 3'd4, 2'd2);
    send("R8", 32'h0, 3'd0, 1'b0, 32'h0, 3'd0, 1'b0,
         32'h0000BEEF, 32'h11223344, 3'd6, 2'd3);
    // R9 idle gap holds outputs
    idle(3);
    // cross sweep: source sign widen and destination merge together
    lf = 32'h1F2E3D4C;
    for (int s = 0; s < 8; s++) begin
      for (int p = 0; p < 4; p++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        send("R1 R2 R5 R6 R7 R8 sweep", lf | 32'h80808080, 3'(s), 1'(p & 1),
             ~lf, 3'(7 - s), 1'(p >> 1), lf ^ 32'h00800080, ~lf ^ 32'h5, 3'(s), 2'(p));
      end
      if (s == 3) idle(2);
    end
    idle(4);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R9 pending results got %0d exp 0", sb.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule